// File: doc/BRIEF.md
# Ten's-Complement BCD Subtractor

This block subtracts one unsigned packed-BCD word from another without any binary subtraction. Every digit of the subtrahend is turned into its nine's complement (nine minus the digit), a forced carry of one enters the lowest digit to make the ten's complement, and a chain of decimal digit adders sums it with the minuend. The carry leaving the top digit is thrown away. When that carry is present the result is the difference. When it is absent the true result is below zero.

For a negative result the block reports a sign flag and the magnitude. It gets the magnitude by taking the ten's complement of the raw sum in a second adder chain. An operand nibble above nine is reported as an invalid operand.

A caller presents both operands with a one-cycle strobe. The answer appears on registered outputs on the following clock edge and stays there until the next strobe. The digit count is a parameter, and the default is three digits.

Top module: `bcd_tc_subtractor`

## Requirements
- R1: While reset is held, and until the first accepted strobe, `out_valid`, `difference`, `negative` and `invalid` are all zero.
- R2: `out_valid` is high for exactly the cycle after a cycle in which `in_valid` was sampled high, and low otherwise.
- R3: If both operands are valid BCD and minuend >= subtrahend, `difference` holds minuend minus subtrahend in packed BCD (digit k in bits 4k+3..4k, least significant digit at bit 0) and `negative` is 0; for example 873 - 218 gives 655.
- R4: If both operands are valid BCD and minuend < subtrahend, `negative` is 1 and `difference` holds subtrahend minus minuend in packed BCD; for example 218 - 873 gives magnitude 655.
- R5: Equal valid operands give `difference` all zeros and `negative` 0, so zero has a single encoding.
- R6: If any nibble of either operand exceeds 9, `invalid` is 1, `difference` is all zeros and `negative` is 0; otherwise `invalid` is 0.
- R7: While `in_valid` is low, `difference`, `negative` and `invalid` keep their values, whatever the operand inputs do.
- R8: Every digit of `difference` lies in 0..9.
- R9: Results that need a decimal carry or borrow across every digit are exact: 000 - 999 is negative 999, 999 - 000 is 999, and 100 - 001 is 099.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset, synchronised on release |
| in_valid | input | 1 | Operand strobe; operands are sampled when high |
| minuend | input | 4*NUM_DIGITS | Packed BCD minuend |
| subtrahend | input | 4*NUM_DIGITS | Packed BCD subtrahend |
| out_valid | output | 1 | High the cycle after an accepted strobe |
| difference | output | 4*NUM_DIGITS | Packed BCD difference, or its magnitude when negative |
| negative | output | 1 | Result was below zero |
| invalid | output | 1 | An operand nibble was above 9 |

## Verification
The properties assume that operands only matter in strobe cycles, and that the strobe stays low until the internally synchronised reset has released. The properties also assume that an operand nibble above nine is legal input, because that case is defined by its own flag. The stimulus holds the strobe low through reset and for several cycles after it. It mixes random valid BCD pairs with pairs in which one nibble is forced to 10..15, and it changes operands in idle cycles so that the hold behaviour is tested against live input changes.

// File: rtl/bcdsub_pkg.sv
package bcdsub_pkg;
  localparam int DIGIT_W = 4;
  localparam logic [DIGIT_W-1:0] DIGIT_MAX = 4'd9;
  localparam logic [DIGIT_W-1:0] DIGIT_FIX = 4'd6;

  typedef logic [DIGIT_W-1:0] digit_t;

  typedef struct packed {
    logic neg;
    logic bad;
  } res_flags_t;
endpackage

// File: rtl/bcdsub_nines.sv
module bcdsub_nines
  import bcdsub_pkg::*;
#(
  parameter int ND = 3,
  localparam int W = ND * DIGIT_W
) (
  input  logic [W-1:0] word_in,
  output logic [W-1:0] word_out
);
  for (genvar k = 0; k < ND; k++) begin : g_dig
    assign word_out[k*DIGIT_W +: DIGIT_W] = DIGIT_MAX - word_in[k*DIGIT_W +: DIGIT_W];
  end
endmodule

// File: rtl/bcdsub_digit_add.sv
module bcdsub_digit_add
  import bcdsub_pkg::*;
(
  input  digit_t a,
  input  digit_t b,
  input  logic   cin,
  output digit_t sum,
  output logic   cout
);
  logic [DIGIT_W:0] raw;

  always_comb begin
    raw  = {1'b0, a} + {1'b0, b} + {{DIGIT_W{1'b0}}, cin};
    cout = (raw > {1'b0, DIGIT_MAX});
    if (cout) begin
      sum = raw[DIGIT_W-1:0] + DIGIT_FIX;
    end else begin
      sum = raw[DIGIT_W-1:0];
    end
  end
endmodule

// File: rtl/bcdsub_chain.sv
module bcdsub_chain
  import bcdsub_pkg::*;
#(
  parameter int ND = 3,
  localparam int W = ND * DIGIT_W
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  logic         cin,
  output logic [W-1:0] sum,
  output logic         cout
);
  logic [ND:0] carry;

  assign carry[0] = cin;

  for (genvar k = 0; k < ND; k++) begin : g_stage
    bcdsub_digit_add u_add (
      .a    (a[k*DIGIT_W +: DIGIT_W]),
      .b    (b[k*DIGIT_W +: DIGIT_W]),
      .cin  (carry[k]),
      .sum  (sum[k*DIGIT_W +: DIGIT_W]),
      .cout (carry[k+1])
    );
  end

  assign cout = carry[ND];
endmodule

// File: rtl/bcdsub_digit_check.sv
module bcdsub_digit_check
  import bcdsub_pkg::*;
#(
  parameter int ND = 3,
  localparam int W = ND * DIGIT_W
) (
  input  logic [W-1:0] word_in,
  output logic         bad
);
  logic [ND-1:0] over;

  for (genvar k = 0; k < ND; k++) begin : g_dig
    assign over[k] = (word_in[k*DIGIT_W +: DIGIT_W] > DIGIT_MAX);
  end

  assign bad = |over;
endmodule

// File: rtl/bcd_tc_subtractor.sv
module bcd_tc_subtractor
  import bcdsub_pkg::*;
#(
  parameter int NUM_DIGITS = 3,
  localparam int W = NUM_DIGITS * DIGIT_W
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         in_valid,
  input  logic [W-1:0] minuend,
  input  logic [W-1:0] subtrahend,
  output logic         out_valid,
  output logic [W-1:0] difference,
  output logic         negative,
  output logic         invalid
);
  // reset release synchroniser
  logic rst_meta_q;
  logic rst_sync_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_q <= 1'b0;
      rst_sync_n <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      rst_sync_n <= rst_meta_q;
    end
  end

  // datapath: minuend + nines(subtrahend) + 1
  logic [W-1:0] sub_nc;
  logic [W-1:0] raw_sum;
  logic         raw_cout;
  logic [W-1:0] raw_nc;
  logic [W-1:0] mag_sum;
  logic         mag_cout;
  logic         min_bad;
  logic         sub_bad;
  logic         op_bad;

  bcdsub_nines #(.ND(NUM_DIGITS)) u_nc_sub (
    .word_in  (subtrahend),
    .word_out (sub_nc)
  );

  bcdsub_chain #(.ND(NUM_DIGITS)) u_main_add (
    .a    (minuend),
    .b    (sub_nc),
    .cin  (1'b1),
    .sum  (raw_sum),
    .cout (raw_cout)
  );

  // magnitude of a negative result: ten's complement of the raw sum
  bcdsub_nines #(.ND(NUM_DIGITS)) u_nc_raw (
    .word_in  (raw_sum),
    .word_out (raw_nc)
  );

  bcdsub_chain #(.ND(NUM_DIGITS)) u_mag_add (
    .a    (raw_nc),
    .b    ({W{1'b0}}),
    .cin  (1'b1),
    .sum  (mag_sum),
    .cout (mag_cout)
  );

  bcdsub_digit_check #(.ND(NUM_DIGITS)) u_chk_min (
    .word_in (minuend),
    .bad     (min_bad)
  );

  bcdsub_digit_check #(.ND(NUM_DIGITS)) u_chk_sub (
    .word_in (subtrahend),
    .bad     (sub_bad)
  );

  assign op_bad = min_bad | sub_bad;

  // next-state selection
  logic [W-1:0] diff_d;
  res_flags_t   flags_d;

  always_comb begin
    if (op_bad) begin
      diff_d      = '0;
      flags_d.neg = 1'b0;
      flags_d.bad = 1'b1;
    end else if (raw_cout) begin
      diff_d      = raw_sum;
      flags_d.neg = 1'b0;
      flags_d.bad = 1'b0;
    end else begin
      diff_d      = mag_sum;
      flags_d.neg = 1'b1;
      flags_d.bad = 1'b0;
    end
  end

  // result registers, loaded on strobe
  logic [W-1:0] diff_q;
  res_flags_t   flags_q;
  logic         vld_q;

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      vld_q   <= 1'b0;
      diff_q  <= '0;
      flags_q <= '0;
    end else begin
      vld_q <= in_valid;
      if (in_valid) begin
        diff_q  <= diff_d;
        flags_q <= flags_d;
      end
    end
  end

  assign out_valid  = vld_q;
  assign difference = diff_q;
  assign negative   = flags_q.neg;
  assign invalid    = flags_q.bad;
endmodule

// File: rtl/bcd_tc_subtractor_chk.sv
module bcd_tc_subtractor_chk #(
  parameter int ND = 3,
  localparam int W = ND * 4
) (
  input logic         clk,
  input logic         rst_sync_n,
  input logic         in_valid,
  input logic [W-1:0] minuend,
  input logic [W-1:0] subtrahend,
  input logic         out_valid,
  input logic [W-1:0] difference,
  input logic         negative,
  input logic         invalid,
  input logic         raw_cout,
  input logic         mag_cout,
  input logic         op_bad
);
  function automatic logic has_bad(input logic [W-1:0] w);
    logic r;
    r = 1'b0;
    for (int k = 0; k < ND; k++) begin
      if (w[k*4 +: 4] > 4'd9) r = 1'b1;
    end
    return r;
  endfunction

  p_valid_timing_r2: assert property (@(posedge clk) disable iff (!rst_sync_n)
    in_valid |=> out_valid);

  p_valid_idle_r2: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !in_valid |=> !out_valid);

  p_hold_r7: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !in_valid |=> ($stable(difference) && $stable(negative) && $stable(invalid)));

  p_invalid_flag_r6: assert property (@(posedge clk) disable iff (!rst_sync_n)
    in_valid |=> (invalid == has_bad($past(minuend)) || invalid == has_bad($past(subtrahend)))
                 && (invalid == (has_bad($past(minuend)) | has_bad($past(subtrahend)))));

  p_invalid_zero_r6: assert property (@(posedge clk) disable iff (!rst_sync_n)
    invalid |-> (difference == '0 && !negative));

  p_single_zero_r5: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (in_valid && minuend == subtrahend && !has_bad(minuend)) |=> (difference == '0 && !negative));

  p_neg_nonzero_r4: assert property (@(posedge clk) disable iff (!rst_sync_n)
    negative |-> (difference != '0 && !invalid));

  p_mag_no_carry_r4: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (!op_bad && !raw_cout) |-> !mag_cout);

  for (genvar k = 0; k < ND; k++) begin : g_dig
    p_digit_legal_r8: assert property (@(posedge clk) disable iff (!rst_sync_n)
      difference[k*4 +: 4] <= 4'd9);
  end
endmodule

bind bcd_tc_subtractor bcd_tc_subtractor_chk #(.ND(NUM_DIGITS)) chk_i (
  .clk        (clk),
  .rst_sync_n (rst_sync_n),
  .in_valid   (in_valid),
  .minuend    (minuend),
  .subtrahend (subtrahend),
  .out_valid  (out_valid),
  .difference (difference),
  .negative   (negative),
  .invalid    (invalid),
  .raw_cout   (raw_cout),
  .mag_cout   (mag_cout),
  .op_bad     (op_bad)
);

// File: tb/bcd_tc_subtractor_tb_top.sv
`timescale 1ns/1ps
module bcd_tc_subtractor_tb_top;
  localparam int ND = 3;
  localparam int W  = ND * 4;

  typedef struct {
    logic [W-1:0] diff;
    logic         neg;
    logic         inv;
    string        req;
  } exp_t;

  logic         clk;
  logic         rst_n;
  logic         in_valid;
  logic [W-1:0] minuend;
  logic [W-1:0] subtrahend;
  logic         out_valid;
  logic [W-1:0] difference;
  logic         negative;
  logic         invalid;

  int   n_checks;
  int   n_fail;
  bit   mon_on;
  bit   done;
  exp_t exp_q[$];
  exp_t last_exp;

  bcd_tc_subtractor #(.NUM_DIGITS(ND)) dut_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .in_valid   (in_valid),
    .minuend    (minuend),
    .subtrahend (subtrahend),
    .out_valid  (out_valid),
    .difference (difference),
    .negative   (negative),
    .invalid    (invalid)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint expv);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, expv);
    end
  endtask

  task automatic report();
    if (!done) begin
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  endtask

  function automatic logic [W-1:0] to_bcd(input int v);
    logic [W-1:0] r;
    int t;
    t = v;
    for (int k = 0; k < ND; k++) begin
      r[k*4 +: 4] = 4'(t % 10);
      t = t / 10;
    end
    return r;
  endfunction

  function automatic int from_bcd(input logic [W-1:0] w);
    int r;
    r = 0;
    for (int k = ND - 1; k >= 0; k--) r = r * 10 + int'(w[k*4 +: 4]);
    return r;
  endfunction

  function automatic bit any_bad(input logic [W-1:0] w);
    bit r;
    r = 1'b0;
    for (int k = 0; k < ND; k++) if (w[k*4 +: 4] > 4'd9) r = 1'b1;
    return r;
  endfunction

  // driver: applies one operand pair and queues the expected result
  task automatic send(input logic [W-1:0] x, input logic [W-1:0] y, input string req);
    exp_t e;
    int   d;
    @(negedge clk);
    in_valid   = 1'b1;
    minuend    = x;
    subtrahend = y;
    e.req = req;
    if (any_bad(x) || any_bad(y)) begin
      e.diff = '0; e.neg = 1'b0; e.inv = 1'b1;
    end else begin
      d = from_bcd(x) - from_bcd(y);
      e.inv = 1'b0;
      e.neg = (d < 0);
      e.diff = to_bcd(d < 0 ? -d : d);
    end
    exp_q.push_back(e);
    last_exp = e;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      in_valid   = 1'b0;
      minuend    = W'($urandom);
      subtrahend = W'($urandom);
    end
  endtask

  // monitor: checks strobe timing and pops results
  initial begin
    forever begin
      logic was_valid;
      exp_t e;
      @(posedge clk);
      was_valid = in_valid;
      #2;
      if (mon_on) begin
        check(out_valid == was_valid, "R2", "out_valid", longint'(out_valid), longint'(was_valid));
        if (out_valid) begin
          if (exp_q.size() == 0) begin
            check(1'b0, "R2", "unexpected result", 1, 0);
          end else begin
            e = exp_q.pop_front();
            check(difference == e.diff, e.req, "difference", longint'(difference), longint'(e.diff));
            check(negative == e.neg, e.req, "negative", longint'(negative), longint'(e.neg));
            check(invalid == e.inv, "R6", "invalid", longint'(invalid), longint'(e.inv));
            for (int k = 0; k < ND; k++) begin
              check(difference[k*4 +: 4] <= 4'd9, "R8", "digit range",
                    longint'(difference[k*4 +: 4]), 9);
            end
          end
        end
      end
    end
  end

  // watchdog
  initial begin
    repeat (150000) @(posedge clk);
    check(1'b0, "WATCHDOG", "timeout", 0, 1);
    report();
  end

  initial begin
    n_checks = 0; n_fail = 0; mon_on = 1'b0; done = 1'b0;
    rst_n = 1'b0; in_valid = 1'b0;
    minuend = '0; subtrahend = '0;
    repeat (3) @(posedge clk);
    #2;
    // R1: reset state
    check(out_valid == 1'b0, "R1", "out_valid in reset", longint'(out_valid), 0);
    check(difference == '0, "R1", "difference in reset", longint'(difference), 0);
    check(negative == 1'b0, "R1", "negative in reset", longint'(negative), 0);
    check(invalid == 1'b0, "R1", "invalid in reset", longint'(invalid), 0);
    @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check(out_valid == 1'b0 && difference == '0 && !negative && !invalid,
          "R1", "state after release", longint'(difference), 0);
    mon_on = 1'b1;

    send(12'h873, 12'h218, "R3");
    send(12'h218, 12'h873, "R4");
    send(12'h456, 12'h456, "R5");
    send(12'h000, 12'h000, "R5");
    send(12'h000, 12'h999, "R9");
    send(12'h999, 12'h000, "R9");
    send(12'h100, 12'h001, "R9");
    send(12'h001, 12'h100, "R9");
    send(12'h8A3, 12'h218, "R6");
    send(12'h218, 12'h00F, "R6");
    idle(1);

    // R7: outputs hold while strobe low and operands move
    send(12'h500, 12'h123, "R3");
    idle(4);
    check(difference == last_exp.diff, "R7", "difference held",
          longint'(difference), longint'(last_exp.diff));
    check(negative == last_exp.neg, "R7", "negative held",
          longint'(negative), longint'(last_exp.neg));
    send(12'h123, 12'h500, "R4");
    idle(3);
    check(negative == 1'b1 && difference == 12'h377, "R7", "negative result held",
          longint'(difference), 12'h377);
    send(12'hFFF, 12'h111, "R6");
    idle(3);
    check(invalid == 1'b1 && difference == '0, "R7", "invalid result held",
          longint'(invalid), 1);

    // random mix, back to back and with gaps
    for (int i = 0; i < 400; i++) begin
      logic [W-1:0] x;
      logic [W-1:0] y;
      x = to_bcd(int'($urandom_range(0, 999)));
      y = to_bcd(int'($urandom_range(0, 999)));
      if (($urandom % 10) == 0) begin
        x[($urandom % ND) * 4 +: 4] = 4'(10 + ($urandom % 6));
      end
      send(x, y, (from_bcd(x) >= from_bcd(y)) ? "R3" : "R4");
      if (($urandom % 4) == 0) idle(1 + int'($urandom % 3));
    end
    idle(4);
    check(exp_q.size() == 0, "R2", "all results seen", longint'(exp_q.size()), 0);
    report();
  end
endmodule